// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a single-stage SIMD multiplier for a media or signal-processing datapath. Two 128-bit operands enter together with an operation select, a narrow-width select and an input strobe. One clock later the 128-bit result leaves together with an output strobe.

The unit offers two operations. The first is a byte dot-product. Each byte of operand A is read as unsigned and each byte of operand B as signed. Each pair of neighbouring byte products is added, and the sum is clamped into the signed 16-bit range. The second is a Q15 fixed-point multiply of signed 16-bit lanes. Each lane's full product is rounded to nearest and then scaled back to Q15.

Both operations are built side by side for every lane. The operation select picks between them in front of the result register. When the narrow select is set, only the low 64 bits of the operands take part.

Top module: `pfx_mul_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to zero on that edge.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high. `result` carries that request's answer in the same cycle.
- R3: With `op_sel` = 0 (dot-product), word k of `result` (bits 16k+15..16k) is A[2k]*B[2k] + A[2k+1]*B[2k+1]. Here A[i] is byte i of `opa` taken as unsigned 0..255, and B[i] is byte i of `opb` taken as signed -128..127.
- R4: In dot-product mode, a pair sum above 32767 gives 0x7FFF, and a pair sum below -32768 gives 0x8000.
- R5: With `op_sel` = 1 (Q15 multiply), lane k of the result is formed in three steps. First, the signed 32-bit product of the two signed 16-bit lanes is arithmetically shifted right by 14. Second, 1 is added. Third, bits 16..1 of that sum are taken.
- R6: In Q15 mode, -32768 times -32768 gives 0x8000. The lane wraps and is not saturated.
- R7: With `half_mode` = 1, words 0..3 follow R3 to R6 on the low 64 bits of the operands, and bits 127..64 of `result` are zero.
- R8: While `in_valid` is low, `result` keeps its previous value whatever the operands, `op_sel` or `half_mode` do.
- R9: If either operand is all zero, the result is all zero in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_sel | input | 1 | 0 = byte dot-product with saturation, 1 = Q15 rounded multiply |
| half_mode | input | 1 | 1 = only the low 64 operand bits are used; the upper result is zero |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| result | output | 128 | Registered result, eight 16-bit words |
| out_valid | output | 1 | Result register was loaded on the last edge |

## Verification
Every lane has its own comb path into a shared output register. A wrong lane computation shows up in exactly one 16-bit word of `result`, one cycle after the strobe, with the other words still correct. The bench therefore compares all eight words of every answer, and uses patterns that differ per lane. A wrong load enable or a lost strobe shows up as `result` changing while idle, or as `out_valid` out of step with `in_valid` by one cycle. Both are visible on the first idle cycle after a request.

// File: rtl/pfx_mul_pkg.sv
// Shared definitions for the packed fixed-point multiply unit.
// Assumes 16-bit output lanes built from byte pairs.
package pfx_mul_pkg;
    localparam int LANE_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SUM_W   = 18;

    typedef enum logic {
        OP_DOTB = 1'b0,
        OP_Q15  = 1'b1
    } pfx_op_e;
endpackage

// File: rtl/pfx_dotb_lane.sv
// One 16-bit lane of the byte dot-product: two unsigned-by-signed byte
// products are summed and clamped to the signed 16-bit range.
// Assumes the 'ua' bytes are unsigned and the 'sb' bytes are two's complement.
module pfx_dotb_lane
    import pfx_mul_pkg::*;
(
    input  logic [BYTE_W-1:0]  ua_lo,
    input  logic [BYTE_W-1:0]  ua_hi,
    input  logic [BYTE_W-1:0]  sb_lo,
    input  logic [BYTE_W-1:0]  sb_hi,
    output logic [LANE_W-1:0]  word
);
    localparam int PROD_W = 2 * BYTE_W + 1;

    logic signed [PROD_W-1:0] prod_lo;
    logic signed [PROD_W-1:0] prod_hi;
    logic signed [SUM_W-1:0]  pair_sum;

    // Mixed-sign byte products, widened to a common signed sum width.
    always_comb begin
        prod_lo  = $signed({1'b0, ua_lo}) * $signed(sb_lo);
        prod_hi  = $signed({1'b0, ua_hi}) * $signed(sb_hi);
        pair_sum = SUM_W'(prod_lo) + SUM_W'(prod_hi);
    end

    // Clamp the pair sum into the signed lane range.
    always_comb begin
        if (pair_sum > $signed(SUM_W'(32767)))
            word = {1'b0, {(LANE_W-1){1'b1}}};
        else if (pair_sum < $signed(-SUM_W'(32768)))
            word = {1'b1, {(LANE_W-1){1'b0}}};
        else
            word = pair_sum[LANE_W-1:0];
    end
endmodule

// File: rtl/pfx_q15_lane.sv
// One 16-bit lane of the Q15 rounded multiply: full signed product, keep the
// top 18 bits, add one, emit bits 16..1. The lane wraps and does not saturate.
// Assumes both inputs are two's complement Q15 values.
module pfx_q15_lane
    import pfx_mul_pkg::*;
(
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] word
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int SHIFT  = PROD_W - SUM_W;

    logic signed [PROD_W-1:0] prod;
    logic        [SUM_W-1:0]  rounded;

    // Product, truncation to the top bits and the rounding increment.
    always_comb begin
        prod    = $signed(x) * $signed(y);
        rounded = prod[PROD_W-1:SHIFT] + SUM_W'(1);
        word    = rounded[LANE_W:1];
    end
endmodule

// File: rtl/pfx_mul_unit.sv
// Packed fixed-point multiply unit. Both operation datapaths run in parallel
// for every lane; op_sel chooses one in front of a single result register.
// Assumes operands and selects are stable for the cycle in_valid is high.
module pfx_mul_unit
    import pfx_mul_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int HALF_LANES = NUM_LANES / 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          op_sel,
    input  logic                          half_mode,
    input  logic [NUM_LANES*LANE_W-1:0]   opa,
    input  logic [NUM_LANES*LANE_W-1:0]   opb,
    output logic [NUM_LANES*LANE_W-1:0]   result,
    output logic                          out_valid
);
    localparam int DATA_W = NUM_LANES * LANE_W;

    logic [DATA_W-1:0] dotb_res;
    logic [DATA_W-1:0] q15_res;
    logic [DATA_W-1:0] next_res;
    pfx_op_e           op;

    assign op = pfx_op_e'(op_sel);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int LO = k * LANE_W;
        logic lane_on;

        pfx_dotb_lane u_dotb (
            .ua_lo (opa[LO +: BYTE_W]),
            .ua_hi (opa[LO + BYTE_W +: BYTE_W]),
            .sb_lo (opb[LO +: BYTE_W]),
            .sb_hi (opb[LO + BYTE_W +: BYTE_W]),
            .word  (dotb_res[LO +: LANE_W])
        );

        pfx_q15_lane u_q15 (
            .x    (opa[LO +: LANE_W]),
            .y    (opb[LO +: LANE_W]),
            .word (q15_res[LO +: LANE_W])
        );

        // Upper lanes are silenced in narrow mode.
        if (k < HALF_LANES) begin : g_low
            assign lane_on = 1'b1;
        end else begin : g_high
            assign lane_on = ~half_mode;
        end

        // Pick the requested operation for this lane.
        always_comb begin
            if (!lane_on)
                next_res[LO +: LANE_W] = '0;
            else if (op == OP_Q15)
                next_res[LO +: LANE_W] = q15_res[LO +: LANE_W];
            else
                next_res[LO +: LANE_W] = dotb_res[LO +: LANE_W];
        end
    end

    // Result register, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (in_valid)
            result <= next_res;
    end

    // Output strobe, one cycle behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end
endmodule

// File: rtl/pfx_mul_unit_chk.sv
// Port-level checker for pfx_mul_unit, attached by bind.
module pfx_mul_unit_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              half_mode,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] result,
    input logic              out_valid
);
    logic rst_q;
    logic seen_edge;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) begin
        rst_q     <= rst_n;
        seen_edge <= 1'b1;
    end

    // R1: after an edge taken in reset, both outputs are zero.
    always_ff @(posedge clk) begin
        if (seen_edge === 1'b1 && rst_q === 1'b0)
            p_reset_clear_r1: assert (!out_valid && result == '0);
    end

    p_valid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_half_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_mode) |=> (result[DATA_W-1:DATA_W/2] == '0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opa == '0 || opb == '0)) |=> (result == '0));
endmodule

bind pfx_mul_unit pfx_mul_unit_chk #(.DATA_W(NUM_LANES*16)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .half_mode (half_mode),
    .opa       (opa),
    .opb       (opb),
    .result    (result),
    .out_valid (out_valid)
);

// File: tb/pfx_mul_unit_tb.sv
// Directed bench for pfx_mul_unit; one task per scenario.
module pfx_mul_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sel = 1'b0;
    logic         half_mode = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic         out_valid;

    int n_checks = 0;
    int n_errors = 0;

    pfx_mul_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .half_mode (half_mode),
        .opa       (opa),
        .opb       (opb),
        .result    (result),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_dotb(input logic [W-1:0] a, input logic [W-1:0] b, input logic half);
        logic [W-1:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            int s;
            logic [7:0] u0, u1;
            logic signed [7:0] s0, s1;
            u0 = a[16*k +: 8];
            u1 = a[16*k+8 +: 8];
            s0 = b[16*k +: 8];
            s1 = b[16*k+8 +: 8];
            s = int'(u0) * int'(s0) + int'(u1) * int'(s1);
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            if (!(half && k >= 4)) r[16*k +: 16] = s[15:0];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_q15(input logic [W-1:0] a, input logic [W-1:0] b, input logic half);
        logic [W-1:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            logic signed [15:0] x, y;
            longint p;
            x = a[16*k +: 16];
            y = b[16*k +: 16];
            p = longint'(x) * longint'(y);
            p = (p >>> 14) + 1;
            if (!(half && k >= 4)) r[16*k +: 16] = p[16:1];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request and compare the answer one cycle later.
    task automatic run_op(input string req, input logic op, input logic half,
                          input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] exp;
        exp = op ? ref_q15(a, b, half) : ref_dotb(a, b, half);
        @(negedge clk);
        opa = a; opb = b; op_sel = op; half_mode = half; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, W'(out_valid), W'(1));
        check(req, result, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid", W'(out_valid), W'(0));
        check("R1 result", result, '0);
    endtask

    task automatic t_dotb_basic();
        run_op("R3 ascending", 1'b0, 1'b0,
               128'h0f0e0d0c0b0a09080706050403020100, 128'hfffefdfc04030201f8f9fafb05f6f7f8);
        run_op("R3 mixed", 1'b0, 1'b0,
               128'h80ff017f00102030405060708090a0b0, 128'h7f80ff01c0400a0bf0e0d0c0b0a09080);
    endtask

    task automatic t_dotb_sat();
        run_op("R4 positive clamp", 1'b0, 1'b0, {16{8'hff}}, {16{8'h7f}});
        run_op("R4 negative clamp", 1'b0, 1'b0, {16{8'hff}}, {16{8'h80}});
        check("R4 word value", result[15:0], W'(16'h8000));
    endtask

    task automatic t_q15();
        run_op("R5 half squared", 1'b1, 1'b0, {8{16'h4000}}, {8{16'h4000}});
        check("R5 lane value", W'(result[15:0]), W'(16'h2000));
        run_op("R5 mixed", 1'b1, 1'b0,
               128'h7fff8001123456789abcdef001000005, 128'h7fff7fff0003fffe4000c000ffff8000);
    endtask

    task automatic t_q15_corner();
        run_op("R6 min squared", 1'b1, 1'b0, {8{16'h8000}}, {8{16'h8000}});
        check("R6 lane value", W'(result[127:112]), W'(16'h8000));
    endtask

    task automatic t_half();
        run_op("R7 dot narrow", 1'b0, 1'b1, {16{8'h33}}, {16{8'hc1}});
        check("R7 upper zero", W'(result[127:64]), '0);
        run_op("R7 q15 narrow", 1'b1, 1'b1, {8{16'h5555}}, {8{16'h9abc}});
    endtask

    task automatic t_hold();
        logic [W-1:0] kept;
        run_op("R8 setup", 1'b0, 1'b0, {8{16'h0102}}, {8{16'h0304}});
        kept = result;
        @(negedge clk);
        opa = {W{1'b1}}; opb = {8{16'h8000}}; op_sel = 1'b1; half_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 result held", result, kept);
        check("R2 no strobe when idle", W'(out_valid), W'(0));
    endtask

    task automatic t_zero();
        run_op("R9 zero A dot", 1'b0, 1'b0, '0, {16{8'h9c}});
        run_op("R9 zero B q15", 1'b1, 1'b0, {8{16'h8000}}, '0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            run_op(i[0] ? "R5 random" : "R3 random", i[0], i[2] & i[1], a, b);
        end
    endtask

    // Back-to-back requests: each answer lands on the cycle after its strobe.
    task automatic t_stream();
        logic [W-1:0] a0, a1;
        a0 = {8{16'h1234}};
        a1 = {8{16'h7f00}};
        @(negedge clk);
        opa = a0; opb = a1; op_sel = 1'b1; half_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R2 first answer", result, ref_q15(a0, a1, 1'b0));
        opa = a1; opb = a0; op_sel = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second strobe", W'(out_valid), W'(1));
        check("R2 second answer", result, ref_dotb(a1, a0, 1'b0));
        @(negedge clk);
        check("R2 strobe drops", W'(out_valid), W'(0));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_dotb_basic();
        t_dotb_sat();
        t_q15();
        t_q15_corner();
        t_half();
        t_hold();
        t_zero();
        t_stream();
        t_random();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset result", result, '0);
        check("R1 re-reset out_valid", W'(out_valid), W'(0));
        finish_run();
    end
endmodule